// File: doc/BRIEF.md
# Group Register Rename Unit

This block renames a group of up to four instructions in a single cycle for an out-of-order core. Each slot carries two 5-bit source register numbers and an optional 5-bit destination register number. The sources are translated into physical register tags through a direct-indexed mapping RAM. Each destination gets a fresh physical tag from a free-tag ring. For each destination the block also returns the physical tag it displaced, so that a later retirement stage can recycle it.

Inside a group, every source is compared with the destinations of all older slots in that group. When one or more of those older destinations match, the tag just allocated to the youngest of them replaces the value read from the RAM. A chain of dependent instructions can therefore be renamed in one cycle. The block keeps a single snapshot of the mapping RAM and the free-ring position. A restore request brings that snapshot back, for example after a mispredicted branch.

Results are combinational in the cycle the group is presented. The mapping RAM and the free-ring position change at the next clock edge, and only when the group is accepted.

Top module: `group_renamer`

## Requirements
- R1: After reset, logical register r maps to physical tag r for every r from 0 to 31, the free ring holds the 32 tags 32..63, and it hands them out in ascending order starting with 32. The snapshot also equals this reset state.
- R2: A source with no matching destination in an older slot of the same group receives the mapping RAM entry for its register number.
- R3: A source whose register number equals the destination of one or more older slots in the group receives the new tag of the youngest such slot.
- R4: Each valid slot with a nonzero destination receives the next tag from the free ring. Slots are served in slot order, 0 first. The tags given out within a group are distinct and lie in 32..63.
- R5: The displaced tag of a destination is the mapping RAM entry for that register. If an older slot in the same group writes the same register, the displaced tag is instead the new tag of the youngest such older slot.
- R6: An accepted group updates the mapping RAM at the next clock edge. When several slots write the same register, the youngest slot's tag is kept. A group presented in the following cycle sees the updated mapping.
- R7: Register 0 is never renamed. A source of 0 always yields tag 0. A destination of 0 takes no tag, and its new and displaced tag outputs are 0.
- R8: If the free ring holds fewer tags than the group's nonzero destinations need, grp_stall is high and grp_fire is low. In that case no tag is taken and the mapping is not changed. A cycle with no valid slot raises neither grp_fire nor grp_stall.
- R9: ckpt_save records the mapping RAM and the free-ring position as they stand at the start of that cycle, before the same cycle's group takes effect. ckpt_restore returns both to the snapshot by the next cycle. Restore takes priority: in a restore cycle the group is neither accepted nor stalled, and a save in that cycle is ignored.
- R10: A slot whose valid bit is low takes no tag, writes nothing, and drives 0 on its new and displaced tag outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_vld | input | 4 | Slot valid bits, bit i for slot i |
| grp_has_dst | input | 4 | Slot has a destination register |
| grp_src_a | input | 20 | First source register, slot i at bits 5i+4:5i |
| grp_src_b | input | 20 | Second source register, same packing |
| grp_dst | input | 20 | Destination register, same packing |
| ckpt_save | input | 1 | Record the mapping snapshot |
| ckpt_restore | input | 1 | Restore the mapping snapshot |
| grp_fire | output | 1 | Group accepted this cycle |
| grp_stall | output | 1 | Group refused for lack of free tags |
| out_tag_a | output | 24 | Physical tag of first source, slot i at bits 6i+5:6i |
| out_tag_b | output | 24 | Physical tag of second source |
| out_tag_new | output | 24 | Newly allocated destination tag |
| out_tag_old | output | 24 | Displaced destination tag |

## Verification
All tag outputs, grp_fire and grp_stall depend combinationally on the current group and the stored state. They are due in the same cycle the group is driven. The bench drives each group just after a falling edge and samples a quarter period later. Updates to the mapping and the free ring, and the effect of a restore, only become visible to the group driven after the next rising edge. The sequential reference model in the bench therefore commits its own state once per sampled cycle, in step with that edge.

// File: rtl/rn_pkg.sv
package rn_pkg;
    parameter int LREG_W = 5;
    parameter int NLOG   = 1 << LREG_W;
    parameter int PTAG_W = 6;
    parameter int NPHYS  = 1 << PTAG_W;
    parameter int GROUP  = 4;
    parameter int NFREE  = NPHYS - NLOG;
    parameter int HEAD_W = $clog2(NFREE);
    parameter int CNT_W  = $clog2(NFREE + 1);

    typedef logic [LREG_W-1:0] lreg_t;
    typedef logic [PTAG_W-1:0] ptag_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic  vld;
        logic  has_dst;
        lreg_t src_a;
        lreg_t src_b;
        lreg_t dst;
    } rn_uop_t;

    typedef struct packed {
        ptag_t tag_a;
        ptag_t tag_b;
        ptag_t tag_new;
        ptag_t tag_old;
    } rn_res_t;

    function automatic logic needs_tag(rn_uop_t u);
        return u.vld && u.has_dst && (u.dst != '0);
    endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table
    import rn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lreg_t rd_a   [GROUP],
    input  lreg_t rd_b   [GROUP],
    input  lreg_t rd_d   [GROUP],
    output ptag_t map_a  [GROUP],
    output ptag_t map_b  [GROUP],
    output ptag_t map_d  [GROUP],
    input  logic  wr_en  [GROUP],
    input  lreg_t wr_idx [GROUP],
    input  ptag_t wr_tag [GROUP],
    input  logic  save,
    input  logic  restore
);
    ptag_t map_q  [NLOG];
    ptag_t snap_q [NLOG];

    always_comb begin
        for (int i = 0; i < GROUP; i++) begin
            map_a[i] = map_q[rd_a[i]];
            map_b[i] = map_q[rd_b[i]];
            map_d[i] = map_q[rd_d[i]];
        end
    end

    // younger slots are written later in the loop and therefore win
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NLOG; r++) begin
                map_q[r]  <= PTAG_W'(r);
                snap_q[r] <= PTAG_W'(r);
            end
        end else if (restore) begin
            for (int r = 0; r < NLOG; r++) map_q[r] <= snap_q[r];
        end else begin
            if (save) begin
                for (int r = 0; r < NLOG; r++) snap_q[r] <= map_q[r];
            end
            for (int i = 0; i < GROUP; i++) begin
                if (wr_en[i]) map_q[wr_idx[i]] <= wr_tag[i];
            end
        end
    end

    assert_reg0_pinned_R7: assert property (@(posedge clk) disable iff (rst)
        map_q[0] == '0);

    assert_young_write_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en[GROUP-1] && !restore) |=> map_q[$past(wr_idx[GROUP-1])] == $past(wr_tag[GROUP-1]));
endmodule

// File: rtl/rn_free_ring.sv
module rn_free_ring
    import rn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cnt_t  pop,
    input  logic  save,
    input  logic  restore,
    output ptag_t next_tag [GROUP],
    output cnt_t  avail
);
    localparam int SUM_W = CNT_W + 1;

    logic [HEAD_W-1:0] head_q, snap_head_q;
    cnt_t              cnt_q,  snap_cnt_q;
    logic [SUM_W-1:0]  head_adv;

    always_comb begin
        for (int k = 0; k < GROUP; k++) begin
            logic [SUM_W-1:0] s;
            s = SUM_W'(head_q) + SUM_W'(k);
            if (s >= SUM_W'(NFREE)) s = s - SUM_W'(NFREE);
            next_tag[k] = PTAG_W'(NLOG) + PTAG_W'(s);
        end
        head_adv = SUM_W'(head_q) + SUM_W'(pop);
        if (head_adv >= SUM_W'(NFREE)) head_adv = head_adv - SUM_W'(NFREE);
    end

    assign avail = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q      <= '0;
            cnt_q       <= CNT_W'(NFREE);
            snap_head_q <= '0;
            snap_cnt_q  <= CNT_W'(NFREE);
        end else if (restore) begin
            head_q <= snap_head_q;
            cnt_q  <= snap_cnt_q;
        end else begin
            if (save) begin
                snap_head_q <= head_q;
                snap_cnt_q  <= cnt_q;
            end
            head_q <= HEAD_W'(head_adv);
            cnt_q  <= cnt_q - pop;
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(NFREE));

    assert_pop_within_avail_R8: assert property (@(posedge clk) disable iff (rst)
        pop <= cnt_q);

    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        !restore |=> cnt_q == $past(cnt_q) - $past(pop));
endmodule

// File: rtl/rn_dep_check.sv
module rn_dep_check
    import rn_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rn_uop_t uop     [GROUP],
    input  ptag_t   map_a   [GROUP],
    input  ptag_t   map_b   [GROUP],
    input  ptag_t   map_d   [GROUP],
    input  ptag_t   new_tag [GROUP],
    output rn_res_t res     [GROUP]
);
    logic wr [GROUP];

    always_comb begin
        for (int i = 0; i < GROUP; i++) wr[i] = needs_tag(uop[i]);
    end

    // quadratic compare: each slot against all older slots, youngest match last
    always_comb begin
        for (int i = 0; i < GROUP; i++) begin
            res[i].tag_a   = map_a[i];
            res[i].tag_b   = map_b[i];
            res[i].tag_old = map_d[i];
            for (int j = 0; j < GROUP; j++) begin
                if (j < i && wr[j]) begin
                    if (uop[j].dst == uop[i].src_a) res[i].tag_a   = new_tag[j];
                    if (uop[j].dst == uop[i].src_b) res[i].tag_b   = new_tag[j];
                    if (uop[j].dst == uop[i].dst)   res[i].tag_old = new_tag[j];
                end
            end
            res[i].tag_new = wr[i] ? new_tag[i] : '0;
            if (!wr[i]) res[i].tag_old = '0;
        end
    end

    generate
        for (genvar g = 1; g < GROUP; g++) begin : g_chk
            assert_fwd_prev_R3: assert property (@(posedge clk) disable iff (rst)
                (wr[g-1] && uop[g].vld && uop[g].src_a == uop[g-1].dst)
                |-> res[g].tag_a == new_tag[g-1]);
            assert_old_prev_R5: assert property (@(posedge clk) disable iff (rst)
                (wr[g-1] && wr[g] && uop[g].dst == uop[g-1].dst)
                |-> res[g].tag_old == new_tag[g-1]);
        end
    endgenerate
endmodule

// File: rtl/group_renamer.sv
module group_renamer
    import rn_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [GROUP-1:0]         grp_vld,
    input  logic [GROUP-1:0]         grp_has_dst,
    input  logic [GROUP*LREG_W-1:0]  grp_src_a,
    input  logic [GROUP*LREG_W-1:0]  grp_src_b,
    input  logic [GROUP*LREG_W-1:0]  grp_dst,
    input  logic                     ckpt_save,
    input  logic                     ckpt_restore,
    output logic                     grp_fire,
    output logic                     grp_stall,
    output logic [GROUP*PTAG_W-1:0]  out_tag_a,
    output logic [GROUP*PTAG_W-1:0]  out_tag_b,
    output logic [GROUP*PTAG_W-1:0]  out_tag_new,
    output logic [GROUP*PTAG_W-1:0]  out_tag_old
);
    rn_uop_t uop     [GROUP];
    lreg_t   rd_a    [GROUP];
    lreg_t   rd_b    [GROUP];
    lreg_t   rd_d    [GROUP];
    ptag_t   map_a   [GROUP];
    ptag_t   map_b   [GROUP];
    ptag_t   map_d   [GROUP];
    ptag_t   ring    [GROUP];
    ptag_t   new_tag [GROUP];
    logic    wr_en   [GROUP];
    rn_res_t res     [GROUP];
    cnt_t    need, avail, pop;
    logic    any_vld, enough;

    generate
        for (genvar g = 0; g < GROUP; g++) begin : g_slot
            assign uop[g].vld     = grp_vld[g];
            assign uop[g].has_dst = grp_has_dst[g];
            assign uop[g].src_a   = grp_src_a[g*LREG_W +: LREG_W];
            assign uop[g].src_b   = grp_src_b[g*LREG_W +: LREG_W];
            assign uop[g].dst     = grp_dst[g*LREG_W +: LREG_W];
            assign rd_a[g]        = uop[g].src_a;
            assign rd_b[g]        = uop[g].src_b;
            assign rd_d[g]        = uop[g].dst;
            assign wr_en[g]       = grp_fire && needs_tag(uop[g]);
            assign out_tag_a[g*PTAG_W +: PTAG_W]   = res[g].tag_a;
            assign out_tag_b[g*PTAG_W +: PTAG_W]   = res[g].tag_b;
            assign out_tag_new[g*PTAG_W +: PTAG_W] = res[g].tag_new;
            assign out_tag_old[g*PTAG_W +: PTAG_W] = res[g].tag_old;

            assert_zero_src_R7: assert property (@(posedge clk) disable iff (rst)
                (grp_fire && grp_vld[g] && grp_src_a[g*LREG_W +: LREG_W] == '0)
                |-> out_tag_a[g*PTAG_W +: PTAG_W] == '0);
            assert_fresh_range_R4: assert property (@(posedge clk) disable iff (rst)
                wr_en[g] |-> out_tag_new[g*PTAG_W +: PTAG_W] >= PTAG_W'(NLOG));
            assert_idle_slot_R10: assert property (@(posedge clk) disable iff (rst)
                !grp_vld[g] |-> (out_tag_new[g*PTAG_W +: PTAG_W] == '0
                              && out_tag_old[g*PTAG_W +: PTAG_W] == '0));
        end
    endgenerate

    // prefix allocation: slot i takes the ring entry after all older takers
    always_comb begin
        int idx;
        idx  = 0;
        need = '0;
        for (int i = 0; i < GROUP; i++) begin
            new_tag[i] = ring[idx];
            if (needs_tag(uop[i])) begin
                idx  = idx + 1;
                need = need + 1'b1;
            end
        end
    end

    assign any_vld   = |grp_vld;
    assign enough    = need <= avail;
    assign grp_fire  = any_vld && !ckpt_restore && enough;
    assign grp_stall = any_vld && !ckpt_restore && !enough;
    assign pop       = grp_fire ? need : '0;

    rn_map_table u_map (
        .clk     (clk),
        .rst     (rst),
        .rd_a    (rd_a),
        .rd_b    (rd_b),
        .rd_d    (rd_d),
        .map_a   (map_a),
        .map_b   (map_b),
        .map_d   (map_d),
        .wr_en   (wr_en),
        .wr_idx  (rd_d),
        .wr_tag  (new_tag),
        .save    (ckpt_save),
        .restore (ckpt_restore)
    );

    rn_free_ring u_ring (
        .clk      (clk),
        .rst      (rst),
        .pop      (pop),
        .save     (ckpt_save),
        .restore  (ckpt_restore),
        .next_tag (ring),
        .avail    (avail)
    );

    rn_dep_check u_dep (
        .clk     (clk),
        .rst     (rst),
        .uop     (uop),
        .map_a   (map_a),
        .map_b   (map_b),
        .map_d   (map_d),
        .new_tag (new_tag),
        .res     (res)
    );

    assert_fire_stall_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(grp_fire && grp_stall));

    assert_restore_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        ckpt_restore |-> (!grp_fire && !grp_stall));
endmodule

// File: tb/group_renamer_tb.sv
module group_renamer_tb;
    import rn_pkg::*;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [GROUP-1:0]        grp_vld, grp_has_dst;
    logic [GROUP*LREG_W-1:0] grp_src_a, grp_src_b, grp_dst;
    logic                    ckpt_save, ckpt_restore;
    logic                    grp_fire, grp_stall;
    logic [GROUP*PTAG_W-1:0] out_tag_a, out_tag_b, out_tag_new, out_tag_old;

    logic b_vld [GROUP];
    logic b_hd  [GROUP];
    int   b_sa  [GROUP];
    int   b_sb  [GROUP];
    int   b_d   [GROUP];

    int m_map [NLOG];
    int c_map [NLOG];
    int m_head, m_cnt, c_head, c_cnt;
    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < GROUP; i++) begin
            grp_vld[i]     = b_vld[i];
            grp_has_dst[i] = b_hd[i];
            grp_src_a[i*LREG_W +: LREG_W] = LREG_W'(b_sa[i]);
            grp_src_b[i*LREG_W +: LREG_W] = LREG_W'(b_sb[i]);
            grp_dst[i*LREG_W +: LREG_W]   = LREG_W'(b_d[i]);
        end
    end

    group_renamer u_dut (
        .clk(clk), .rst(rst), .grp_vld(grp_vld), .grp_has_dst(grp_has_dst),
        .grp_src_a(grp_src_a), .grp_src_b(grp_src_b), .grp_dst(grp_dst),
        .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore),
        .grp_fire(grp_fire), .grp_stall(grp_stall),
        .out_tag_a(out_tag_a), .out_tag_b(out_tag_b),
        .out_tag_new(out_tag_new), .out_tag_old(out_tag_old)
    );

    task automatic model_reset();
        for (int r = 0; r < NLOG; r++) begin
            m_map[r] = r;
            c_map[r] = r;
        end
        m_head = 0; m_cnt = NFREE; c_head = 0; c_cnt = NFREE;
    endtask

    task automatic clear_group();
        for (int i = 0; i < GROUP; i++) begin
            b_vld[i] = 1'b0; b_hd[i] = 1'b0; b_sa[i] = 0; b_sb[i] = 0; b_d[i] = 0;
        end
        ckpt_save = 1'b0;
        ckpt_restore = 1'b0;
    endtask

    task automatic set_slot(input int i, input bit v, input bit hd,
                            input int sa, input int sb, input int d);
        b_vld[i] = v; b_hd[i] = hd; b_sa[i] = sa; b_sb[i] = sb; b_d[i] = d;
    endtask

    task automatic cmp(input string lbl, input string req, input int act, input int exp, inout bit bad);
        if (act != exp) begin
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, lbl, act, exp, $time);
            bad = 1'b1;
        end
    endtask

    // one cycle: sample quarter period after the negedge drive, then commit model
    task automatic step(input string lbl);
        int  e_a [GROUP];
        int  e_b [GROUP];
        int  e_n [GROUP];
        int  e_o [GROUP];
        bit  e_fire, e_stall, any, bad;
        int  need;
        e_fire = 0; e_stall = 0; any = 0; bad = 0; need = 0;
        for (int i = 0; i < GROUP; i++) begin
            e_a[i] = 0; e_b[i] = 0; e_n[i] = 0; e_o[i] = 0;
            if (b_vld[i]) any = 1;
            if (b_vld[i] && b_hd[i] && b_d[i] != 0) need++;
        end
        #(CLK_P/4);
        if (ckpt_restore) begin
            m_map = c_map; m_head = c_head; m_cnt = c_cnt;
        end else begin
            if (ckpt_save) begin
                c_map = m_map; c_head = m_head; c_cnt = m_cnt;
            end
            if (any && need <= m_cnt) begin
                e_fire = 1;
                for (int i = 0; i < GROUP; i++) begin
                    if (b_vld[i]) begin
                        e_a[i] = m_map[b_sa[i]];
                        e_b[i] = m_map[b_sb[i]];
                        if (b_hd[i] && b_d[i] != 0) begin
                            e_o[i] = m_map[b_d[i]];
                            e_n[i] = NLOG + m_head;
                            m_head = (m_head + 1) % NFREE;
                            m_map[b_d[i]] = e_n[i];
                        end
                    end
                end
                m_cnt = m_cnt - need;
            end else if (any) begin
                e_stall = 1;
            end
        end
        cmp(lbl, "R8 fire", int'(grp_fire), int'(e_fire), bad);
        cmp(lbl, "R8 stall", int'(grp_stall), int'(e_stall), bad);
        if (e_fire) begin
            for (int i = 0; i < GROUP; i++) begin
                if (b_vld[i]) begin
                    cmp(lbl, "R2/R3 tag_a", int'(out_tag_a[i*PTAG_W +: PTAG_W]), e_a[i], bad);
                    cmp(lbl, "R2/R3 tag_b", int'(out_tag_b[i*PTAG_W +: PTAG_W]), e_b[i], bad);
                end
                cmp(lbl, "R4/R10 tag_new", int'(out_tag_new[i*PTAG_W +: PTAG_W]), e_n[i], bad);
                cmp(lbl, "R5/R10 tag_old", int'(out_tag_old[i*PTAG_W +: PTAG_W]), e_o[i], bad);
            end
        end
        n_vec++;
        if (bad) n_bad++;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired: actual hung expected done");
        n_bad++;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        clear_group();
        model_reset();
        repeat (3) @(negedge clk);
        // R1: idle outputs during reset
        #(CLK_P/4);
        n_vec++;
        if (grp_fire !== 1'b0 || grp_stall !== 1'b0) begin
            $display("FAIL R1 reset: actual fire=%0b stall=%0b expected 0 0", grp_fire, grp_stall);
            n_bad++;
        end
        @(negedge clk);
        rst = 1'b0;

        // R1: identity map, R9 save at reset state
        clear_group();
        ckpt_save = 1'b1;
        for (int i = 0; i < GROUP; i++) set_slot(i, 1, 0, 1 + 2*i, 2 + 2*i, 0);
        step("R1 identity read");
        clear_group();
        for (int i = 0; i < GROUP; i++) set_slot(i, 1, 1, 9 + i, 17 + i, 20 + i);
        step("R1 first tags 32..35");

        // R6: previous writes visible, R3 dependency chain on r5
        clear_group();
        for (int i = 0; i < GROUP; i++) set_slot(i, 1, 0, 20 + i, 23 - i, 0);
        step("R6 next-cycle visibility");
        clear_group();
        set_slot(0, 1, 1, 1, 2, 5);
        set_slot(1, 1, 1, 5, 5, 5);
        set_slot(2, 1, 0, 5, 3, 0);
        set_slot(3, 1, 1, 5, 1, 5);
        step("R3 R5 chain on r5");
        clear_group();
        set_slot(0, 1, 0, 5, 0, 0);
        step("R6 youngest r5 kept");

        // R7: register 0 everywhere; R10 invalid slot with dst fields
        clear_group();
        set_slot(0, 1, 1, 0, 0, 0);
        set_slot(1, 0, 1, 7, 7, 7);
        set_slot(2, 1, 1, 0, 6, 6);
        set_slot(3, 1, 0, 6, 0, 0);
        step("R7 R10 zero and idle slot");

        // R9: restore to reset snapshot
        clear_group();
        ckpt_restore = 1'b1;
        for (int i = 0; i < GROUP; i++) set_slot(i, 1, 1, i, i, 10 + i);
        step("R9 restore cycle quiet");
        clear_group();
        set_slot(0, 1, 1, 5, 20, 8);
        step("R9 after restore");

        // R8: drain the ring to the edge
        clear_group();
        ckpt_restore = 1'b1;
        step("R9 restore again");
        for (int k = 0; k < 7; k++) begin
            clear_group();
            for (int i = 0; i < GROUP; i++) set_slot(i, 1, 1, k, i, 1 + ((k*GROUP + i) % 31));
            step("R4 drain");
        end
        clear_group();
        set_slot(0, 1, 1, 3, 4, 3); set_slot(1, 1, 1, 3, 3, 9); set_slot(2, 1, 1, 9, 3, 11);
        step("R4 three tags leave one");
        clear_group();
        set_slot(0, 1, 1, 3, 4, 12); set_slot(3, 1, 1, 12, 4, 13);
        step("R8 two needed one free");
        clear_group();
        set_slot(1, 1, 1, 12, 13, 14); set_slot(2, 1, 0, 14, 0, 0);
        step("R8 last tag 63");
        clear_group();
        set_slot(0, 1, 1, 14, 1, 15);
        step("R8 empty ring stall");
        clear_group();
        set_slot(0, 1, 1, 14, 0, 0); set_slot(1, 1, 0, 14, 2, 0);
        step("R8 no-dst group fires on empty ring");
        clear_group();
        ckpt_restore = 1'b1;
        step("R9 refill by restore");

        // random traffic
        for (int n = 0; n < 1500; n++) begin
            clear_group();
            for (int i = 0; i < GROUP; i++) begin
                int lim;
                lim = ($urandom % 4 == 0) ? 32 : 8;
                set_slot(i, ($urandom % 5) != 0, ($urandom % 3) != 0,
                         $urandom % lim, $urandom % lim, $urandom % lim);
            end
            if (m_cnt < 3 && ($urandom % 3) == 0) ckpt_restore = 1'b1;
            else if (($urandom % 40) == 0) ckpt_restore = 1'b1;
            else if (m_cnt > 26 && ($urandom % 4) == 0) ckpt_save = 1'b1;
            step("R2 R3 R5 R6 R9 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule